// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical raster timing for a bitmap display controller. Software programs it through one 32-bit write port. The top byte of each word picks a register, and a value field starting at bit 14 carries the timing value. From the programmed values, a pixel-position counter and a line counter run through each line and each frame. The block drives horizontal and vertical sync, a border-active flag, a display-active flag, a blanking flag, a pixel clock enable, the current colour depth, and the half-line position used for interlaced fields.

Horizontal values count in two-pixel units. Each horizontal register has its own offset. The display start and display end values also carry a skew that depends on colour depth, and the comparator removes this skew so the visible window falls on the intended pixels.

Writes go into shadow registers. The shadow values are copied into the working set only at a frame boundary, so a frame already in progress is never mixed. Nothing runs until the control register has been written.

Top module: `vid_timing_gen`

## Requirements
- R1: A write stores the value field `wr_data[14 +: HW]` (horizontal) or `wr_data[14 +: VW]` (vertical) into the register picked by `wr_data[31:24]`. The horizontal selects are 0x80 total, 0x84 sync width, 0x88 border start, 0x8C display start, 0x90 display end, 0x94 border end and 0x9C interlace position. The vertical selects are 0xA0 total, 0xA4 sync width, 0xA8 border start, 0xAC display start, 0xB0 display end and 0xB4 border end. The control select is 0xE0. A write with any other select changes nothing.
- R2: Once running, new register values reach the outputs only from the frame boundary on. That boundary is the pixel-clock-enabled step after the last pixel of the last line.
- R3: A line lasts 2*Htotal+2 pixel steps. Horizontal sync is active on pixels 0 to 2*Hsync+1 of each line, and control bit 11 inverts the hsync pin.
- R4: The horizontal border region covers pixels from 2*Hborderstart+1 up to, but not including, 2*Hborderend+1.
- R5: The control field at bits 3:2 gives log2 of the bits per pixel and appears on `depth_log2`. The horizontal display region covers pixels from 2*Hdispstart+k up to, but not including, 2*Hdispend+k. The skew k is 19, 11, 7 or 5 for depth codes 0, 1, 2 or 3.
- R6: A frame lasts Vtotal+1 lines. Vsync is active on lines 0 to Vsync, and control bit 12 inverts the vsync pin. Border lines run from above Vborderstart up to and including Vborderend. Display lines run from above Vdispstart up to and including Vdispend.
- R7: `border_act` is the horizontal border region ANDed with the vertical border region. `disp_act` is the horizontal display region ANDed with the vertical display region. `blank` is the inverse of `border_act`.
- R8: The rate field at control bits 1:0 sets how many clocks out of every 6 assert `pix_ce`: 2, 3, 4 or 6 for codes 0, 1, 2 or 3, spread evenly by a modulo-6 accumulator. The position counters advance only on clocks where `pix_ce` is high.
- R9: After reset, `pix_ce`, `border_act` and `disp_act` stay low, `blank` stays high and the sync pins sit at their inactive level. This holds until the control register has been written. Outputs start following the counters from the second clock after that write, beginning at pixel 0 of line 0.
- R10: `ilace_pos` shows the working interlace-position value, and it is updated at the frame boundary like every other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (24 MHz pixel reference) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Select in bits 31:24, value from bit 14, control fields in low bits |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, polarity per control bit 11 |
| vsync | output | 1 | Vertical sync, polarity per control bit 12 |
| border_act | output | 1 | Inside the border (outer) window |
| disp_act | output | 1 | Inside the display window |
| blank | output | 1 | Outside the border window |
| depth_log2 | output | 2 | Working log2 of bits per pixel |
| ilace_pos | output | HW | Working interlace half-line position |

## Verification
A wrong pixel counter moves the edges of hsync, border and display within one line. A wrong line counter moves vsync and the vertical windows within one frame. A wrong depth skew shifts the display window by a few pixels on the very next line that has display-active lines. An accumulator fault breaks the `pix_ce` spacing inside six clocks. Shadow-copy timing errors show up as `depth_log2`, `ilace_pos` or a window edge changing on the wrong clock around a frame boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int VAL_LSB = 14;
  localparam int H_REGS  = 7;
  localparam int V_REGS  = 6;

  // horizontal register slots
  localparam int HI_TOT = 0;
  localparam int HI_SW  = 1;
  localparam int HI_BS  = 2;
  localparam int HI_DS  = 3;
  localparam int HI_DE  = 4;
  localparam int HI_BE  = 5;
  localparam int HI_IL  = 6;

  // vertical register slots
  localparam int VI_TOT = 0;
  localparam int VI_SW  = 1;
  localparam int VI_BS  = 2;
  localparam int VI_DS  = 3;
  localparam int VI_DE  = 4;
  localparam int VI_BE  = 5;

  localparam logic [7:0] SEL_CTRL = 8'hE0;

  function automatic logic [7:0] h_sel(input int i);
    return (i == HI_IL) ? 8'h9C : 8'(8'h80 + 4 * i);
  endfunction

  function automatic logic [7:0] v_sel(input int i);
    return 8'(8'hA0 + 4 * i);
  endfunction

  // pipeline skew folded into display start/end, per depth code
  function automatic logic [4:0] depth_skew(input logic [1:0] d);
    case (d)
      2'd0:    return 5'd19;
      2'd1:    return 5'd11;
      2'd2:    return 5'd7;
      default: return 5'd5;
    endcase
  endfunction

  // enables per 6 reference clocks, per rate code
  function automatic logic [2:0] rate_step(input logic [1:0] r);
    case (r)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
  import vtg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic                     frame_end,
  output logic                     running,
  output logic [H_REGS-1:0][HW-1:0] h_act,
  output logic [V_REGS-1:0][VW-1:0] v_act,
  output logic [1:0]               rate,
  output logic [1:0]               depth,
  output logic [1:0]               pol
);

  logic [7:0]                sel;
  logic [H_REGS-1:0]         h_hit;
  logic [V_REGS-1:0]         v_hit;
  logic                      c_hit;
  logic [H_REGS-1:0][HW-1:0] h_sh;
  logic [V_REGS-1:0][VW-1:0] v_sh;
  logic [5:0]                c_sh, c_act;
  logic                      ctrl_seen;
  logic                      load;
  logic                      unused_wr;

  assign sel       = wr_data[31:24];
  assign c_hit     = wr_en && (sel == SEL_CTRL);
  assign unused_wr = ^{wr_data[23:14], wr_data[13], wr_data[10:4]};

  genvar gi;
  generate
    for (gi = 0; gi < H_REGS; gi++) begin : g_hdec
      assign h_hit[gi] = wr_en && (sel == h_sel(gi));
    end
    for (gi = 0; gi < V_REGS; gi++) begin : g_vdec
      assign v_hit[gi] = wr_en && (sel == v_sel(gi));
    end
  endgenerate

  // shadow registers
  always_ff @(posedge clk) begin
    if (rst) begin
      h_sh      <= '0;
      v_sh      <= '0;
      c_sh      <= '0;
      ctrl_seen <= 1'b0;
    end else begin
      for (int i = 0; i < H_REGS; i++)
        if (h_hit[i]) h_sh[i] <= wr_data[VAL_LSB +: HW];
      for (int i = 0; i < V_REGS; i++)
        if (v_hit[i]) v_sh[i] <= wr_data[VAL_LSB +: VW];
      if (c_hit) begin
        c_sh      <= {wr_data[12:11], wr_data[3:0]};
        ctrl_seen <= 1'b1;
      end
    end
  end

  // working set: tracks shadow while idle, else copied at frame boundary
  assign load = !running || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_act   <= '0;
      v_act   <= '0;
      c_act   <= '0;
      running <= 1'b0;
    end else begin
      running <= ctrl_seen;
      if (load) begin
        h_act <= h_sh;
        v_act <= v_sh;
        c_act <= c_sh;
      end
    end
  end

  assign rate  = c_act[1:0];
  assign depth = c_act[3:2];
  assign pol   = c_act[5:4];

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_end) |=> ($stable(h_act) && $stable(v_act) && $stable(c_act))) // R2
    else $error("working registers changed mid-frame");

endmodule

// File: rtl/vtg_pixce.sv
module vtg_pixce
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       running,
  input  logic [1:0] rate,
  output logic       ce
);

  localparam logic [3:0] MODULUS = 4'd6;

  logic [2:0] acc;
  logic [3:0] sum;
  logic       wrap;

  assign sum  = {1'b0, acc} + {1'b0, rate_step(rate)};
  assign wrap = (sum >= MODULUS);

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      acc <= '0;
      ce  <= 1'b0;
    end else begin
      ce  <= wrap;
      acc <= wrap ? 3'(sum - MODULUS) : sum[2:0];
    end
  end

  AST_CE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !running |=> !ce) // R9
    else $error("pixel enable while idle");

  AST_CE_FULL: assert property (@(posedge clk) disable iff (rst)
    (running && rate == 2'd3) |=> ce) // R8
    else $error("full rate missed an enable");

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      running,
  input  logic                      ce,
  input  logic [H_REGS-1:0][HW-1:0] h_act,
  input  logic [V_REGS-1:0][VW-1:0] v_act,
  input  logic [1:0]                depth,
  input  logic [1:0]                pol,
  output logic                      frame_end,
  output logic                      hsync,
  output logic                      vsync,
  output logic                      border_act,
  output logic                      disp_act,
  output logic                      blank
);

  localparam int HCW = HW + 2;

  logic [HCW-1:0] hc, h_last, sw_end, bs_px, be_px, ds_px, de_px, skew;
  logic [VW-1:0]  vc;
  logic           line_end, last_line;
  logic           h_sync_c, h_bord_c, h_disp_c;
  logic           v_sync_c, v_bord_c, v_disp_c;

  // two-pixel units back to pixel positions
  assign skew   = HCW'(depth_skew(depth));
  assign h_last = {1'b0, h_act[HI_TOT], 1'b1};
  assign sw_end = {1'b0, h_act[HI_SW], 1'b0} + HCW'(2);
  assign bs_px  = {1'b0, h_act[HI_BS], 1'b1};
  assign be_px  = {1'b0, h_act[HI_BE], 1'b1};
  assign ds_px  = {1'b0, h_act[HI_DS], 1'b0} + skew;
  assign de_px  = {1'b0, h_act[HI_DE], 1'b0} + skew;

  assign line_end  = (hc == h_last);
  assign last_line = (vc == v_act[VI_TOT]);
  assign frame_end = running && ce && line_end && last_line;

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      hc <= '0;
      vc <= '0;
    end else if (ce) begin
      if (line_end) begin
        hc <= '0;
        vc <= last_line ? '0 : vc + 1'b1;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  always_comb begin
    h_sync_c = (hc < sw_end);
    h_bord_c = (hc >= bs_px) && (hc < be_px);
    h_disp_c = (hc >= ds_px) && (hc < de_px);
    v_sync_c = (vc <= v_act[VI_SW]);
    v_bord_c = (vc > v_act[VI_BS]) && (vc <= v_act[VI_BE]);
    v_disp_c = (vc > v_act[VI_DS]) && (vc <= v_act[VI_DE]);
  end

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      hsync      <= pol[0];
      vsync      <= pol[1];
      border_act <= 1'b0;
      disp_act   <= 1'b0;
      blank      <= 1'b1;
    end else begin
      hsync      <= h_sync_c ^ pol[0];
      vsync      <= v_sync_c ^ pol[1];
      border_act <= h_bord_c && v_bord_c;
      disp_act   <= h_disp_c && v_disp_c;
      blank      <= !(h_bord_c && v_bord_c);
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !running |=> (hc == '0 && vc == '0)) // R9
    else $error("counters moved while idle");

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    (running && !ce) |=> ($stable(hc) && $stable(vc))) // R8
    else $error("counter moved without enable");

  AST_HC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (running && ce && line_end) |=> (hc == '0)) // R3
    else $error("pixel counter did not wrap");

  AST_HC_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> (hc <= h_last)) // R3
    else $error("pixel counter past line end");

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic          pix_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          border_act,
  output logic          disp_act,
  output logic          blank,
  output logic [1:0]    depth_log2,
  output logic [HW-1:0] ilace_pos
);

  logic                      running, frame_end;
  logic [H_REGS-1:0][HW-1:0] h_act;
  logic [V_REGS-1:0][VW-1:0] v_act;
  logic [1:0]                rate, depth, pol;

  vtg_regfile #(.HW(HW), .VW(VW)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .frame_end(frame_end), .running(running),
    .h_act(h_act), .v_act(v_act), .rate(rate), .depth(depth), .pol(pol)
  );

  vtg_pixce i_ce (
    .clk(clk), .rst(rst), .running(running), .rate(rate), .ce(pix_ce)
  );

  vtg_counters #(.HW(HW), .VW(VW)) i_cnt (
    .clk(clk), .rst(rst), .running(running), .ce(pix_ce),
    .h_act(h_act), .v_act(v_act), .depth(depth), .pol(pol),
    .frame_end(frame_end), .hsync(hsync), .vsync(vsync),
    .border_act(border_act), .disp_act(disp_act), .blank(blank)
  );

  assign depth_log2 = depth;
  assign ilace_pos  = h_act[HI_IL];

endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;

  localparam int HW = 6;
  localparam int VW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          pix_ce, hsync, vsync, border_act, disp_act, blank;
  logic [1:0]    depth_log2;
  logic [HW-1:0] ilace_pos;

  vid_timing_gen #(.HW(HW), .VW(VW)) i_vid_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
    .border_act(border_act), .disp_act(disp_act), .blank(blank),
    .depth_log2(depth_log2), .ilace_pos(ilace_pos)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int sh_h[7], sh_v[6], sh_rate, sh_dep, sh_pol;
  int ah[7], av[6], arate, adep, apol;
  int mh, mv, bacc;
  bit ce_prev, model_on = 0;

  task automatic chk(string tag, int a, int e);
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, a, e, $time);
    end
  endtask

  function automatic int kskew(int d);
    return (d == 0) ? 19 : (d == 1) ? 11 : (d == 2) ? 7 : 5;
  endfunction

  function automatic int rinc(int r);
    return (r == 0) ? 2 : (r == 1) ? 3 : (r == 2) ? 4 : 6;
  endfunction

  task automatic take_shadow();
    for (int i = 0; i < 7; i++) ah[i] = sh_h[i];
    for (int i = 0; i < 6; i++) av[i] = sh_v[i];
    arate = sh_rate; adep = sh_dep; apol = sh_pol;
  endtask

  // one reference clock of the model, called at a falling edge
  task automatic step();
    int t; bit hs, hb, hd, vs, vb, vd, ce;
    hs = mh < 2*ah[1] + 2;
    hb = (mh >= 2*ah[2] + 1) && (mh < 2*ah[5] + 1);
    hd = (mh >= 2*ah[3] + kskew(adep)) && (mh < 2*ah[4] + kskew(adep));
    vs = mv <= av[1];
    vb = (mv > av[2]) && (mv <= av[5]);
    vd = (mv > av[3]) && (mv <= av[4]);
    chk("R3 hsync", int'(hsync), int'(hs) ^ (apol & 1));
    chk("R6 vsync", int'(vsync), int'(vs) ^ ((apol >> 1) & 1));
    chk("R4 R7 border_act", int'(border_act), int'(hb && vb));
    chk("R5 R7 disp_act", int'(disp_act), int'(hd && vd));
    chk("R7 blank", int'(blank), int'(!(hb && vb)));
    t = bacc + rinc(arate);
    ce = (t >= 6);
    bacc = ce ? t - 6 : t;
    chk("R8 pix_ce", int'(pix_ce), int'(ce));
    if (ce_prev) begin
      if (mh == 2*ah[0] + 1) begin
        mh = 0;
        if (mv == av[0]) begin mv = 0; take_shadow(); end
        else mv++;
      end else mh++;
    end
    ce_prev = ce;
    chk("R5 R2 depth_log2", int'(depth_log2), adep);
    chk("R10 R2 ilace_pos", int'(ilace_pos), ah[6]);
  endtask

  task automatic tick();
    @(negedge clk);
    if (model_on) step();
  endtask

  task automatic idle_check(string tag);
    chk({tag, " pix_ce"}, int'(pix_ce), 0);
    chk({tag, " border_act"}, int'(border_act), 0);
    chk({tag, " disp_act"}, int'(disp_act), 0);
    chk({tag, " blank"}, int'(blank), 1);
    chk({tag, " hsync"}, int'(hsync), 0);
    chk({tag, " vsync"}, int'(vsync), 0);
  endtask

  task automatic wr(int sel, int val, int low);
    wr_data = (32'(sel) << 24) | (32'(val) << 14) | 32'(low);
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    if (sel >= 'h80 && sel <= 'h94 && sel % 4 == 0) sh_h[(sel - 'h80) / 4] = val;
    else if (sel == 'h9C) sh_h[6] = val;
    else if (sel >= 'hA0 && sel <= 'hB4 && sel % 4 == 0) sh_v[(sel - 'hA0) / 4] = val;
    else if (sel == 'hE0) begin
      sh_rate = low & 3; sh_dep = (low >> 2) & 3; sh_pol = (low >> 11) & 3;
    end
  endtask

  // new depth with display start/end re-encoded so the window stays on pixels 27..50
  task automatic set_mode(int rate, int dep, int pol, int il);
    wr('h8C, (27 - kskew(dep)) / 2, 0);
    wr('h90, (51 - kskew(dep)) / 2, 0);
    wr('h9C, il, 0);
    wr('hE0, 0, (pol << 11) | (1 << 9) | (dep << 2) | rate);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 7; i++) sh_h[i] = 0;
    for (int i = 0; i < 6; i++) sh_v[i] = 0;
    sh_rate = 0; sh_dep = 0; sh_pol = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R9 reset");

    // line: sync 4, back porch 21, border 2, display 24, border 2, front porch 5
    wr('h80, 28, 0); wr('h84, 1, 0); wr('h88, 12, 0); wr('h94, 26, 0);
    wr('h8C, (27 - 19) / 2, 0); wr('h90, (51 - 19) / 2, 0); wr('h9C, 14, 0);
    // frame: sync 2, porch 2, border 1, display 4, border 1, porch 2
    wr('hA0, 11, 0); wr('hA4, 1, 0); wr('hA8, 3, 0);
    wr('hAC, 4, 0); wr('hB0, 8, 0); wr('hB4, 9, 0);
    // R1: unrecognised selects must leave every register alone
    wr('h98, 63, 0); wr('hB8, 63, 0); wr('h00, 5, 0); wr('h8D, 2, 0);
    wr('hE4, 0, 'h1803); wr('h7C, 7, 0); wr('hA2, 0, 0);
    repeat (40) begin tick(); idle_check("R9 no control yet"); end

    // start: rate 3, depth 0, polarity 0
    wr('hE0, 0, 0 | (2 << 9) | 3);
    idle_check("R9 start+1");
    tick();
    idle_check("R9 start+2");
    take_shadow(); mh = 0; mv = 0; bacc = 0; ce_prev = 0;
    chk("R1 R10 ilace_pos", int'(ilace_pos), 14);
    chk("R1 R5 depth_log2", int'(depth_log2), 0);
    model_on = 1;
    repeat (900) tick();

    set_mode(2, 3, 3, 9);
    chk("R2 depth held after write", int'(depth_log2), adep);
    repeat (2400) tick();
    set_mode(1, 1, 1, 20);
    repeat (3000) tick();
    set_mode(0, 2, 2, 3);
    wr('h55, 1, 0);
    repeat (4400) tick();
    set_mode(3, 3, 0, 11);
    repeat (1600) tick();
    summary();
  end

endmodule